// File: doc/BRIEF.md
# JTAG TAP State Status Indicator

This block follows a JTAG link from the probe side. On every rising edge of the test clock it samples TMS and the active-low test reset, and it keeps its own copy of the 16-state TAP controller. It folds that state into a two-colour code for a status LED. Two more bicolour LEDs show link activity and the power source of the probe.

Four colour codes cover the whole TAP graph. The state LED is dark in Test-Logic-Reset and in every transitional state. It is green in Run-Test/Idle, red while an instruction register is being shifted or paused, and red plus green while a data register is being shifted or paused. The activity LED lights red while test reset is held. It lights green for a stretched time after each host transfer pulse, so that short transfers stay visible. The power LED is green when the host powers the probe and red when the target does. It blinks red when the probe runs from target power, no return clock is seen, and the no-return-clock mode is off.

Top module: `tap_status_led`

## Requirements
- R1: On each rising test-clock edge with trst_n high, the tracked state moves along the standard TAP graph chosen by TMS.
- R2: A low trst_n sampled on a rising edge puts the tracked state in Test-Logic-Reset after that edge.
- R3: Five consecutive rising edges with TMS=1 leave the tracked state in Test-Logic-Reset, from any starting state.
- R4: tap_red and tap_grn are both 0 in Test-Logic-Reset. In Run-Test/Idle, tap_grn is 1 and tap_red is 0.
- R5: In Shift-IR or Pause-IR, only tap_red is 1. In Shift-DR or Pause-DR, both are 1. In every other state, both are 0.
- R6: act_red equals the inverse of trst_n, with no clock delay.
- R7: A host_act pulse sets act_grn after that edge and reloads a count of STRETCH_TICKS. Each later edge with blink_tick and no pulse lowers the count by one. act_grn drops when the count reaches zero. A pulse wins over a tick on the same edge.
- R8: pwr_grn equals pwr_from_host. pwr_red is 0 when pwr_from_host is 1. pwr_red is steadily 1 on target power while retclk_seen or no_retclk_mode is 1.
- R9: A blink phase starts at 0 and toggles on every edge with blink_tick. On target power with retclk_seen=0 and no_retclk_mode=0, pwr_red equals that phase.
- R10: A low rst_n at once forces Test-Logic-Reset, clears the stretch count and clears the blink phase. After rst_n rises, the reset is released on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tms | input | 1 | Test mode select as seen on the link |
| trst_n | input | 1 | Active-low test reset as seen on the link |
| host_act | input | 1 | One-cycle pulse per host transfer |
| pwr_from_host | input | 1 | 1 = probe powered by host, 0 = by target |
| retclk_seen | input | 1 | 1 = return test clock is present |
| no_retclk_mode | input | 1 | 1 = operation without return clock is selected |
| blink_tick | input | 1 | Slow one-cycle tick for blink and stretch timing |
| pwr_red | output | 1 | Power LED red enable |
| pwr_grn | output | 1 | Power LED green enable |
| act_red | output | 1 | Activity LED red enable |
| act_grn | output | 1 | Activity LED green enable |
| tap_red | output | 1 | TAP state LED red enable |
| tap_grn | output | 1 | TAP state LED green enable |

## Verification
A wrong tracked TAP state shows on tap_red/tap_grn as soon as the tracker enters a coloured state (idle, shift or pause). A fault in a transitional state can stay hidden until the walk reaches one of those, usually within a few edges, or until five TMS ones should have brought the LED dark. A stretch count that is off by one drops act_grn one tick early or late. A stuck or misaligned blink phase inverts pwr_red on the next tick edge while the return clock is missing.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

  typedef enum logic [3:0] {
    TAP_RESET   = 4'd0,
    TAP_IDLE    = 4'd1,
    TAP_DR_SEL  = 4'd2,
    TAP_DR_CAP  = 4'd3,
    TAP_DR_SHF  = 4'd4,
    TAP_DR_EX1  = 4'd5,
    TAP_DR_PAU  = 4'd6,
    TAP_DR_EX2  = 4'd7,
    TAP_DR_UPD  = 4'd8,
    TAP_IR_SEL  = 4'd9,
    TAP_IR_CAP  = 4'd10,
    TAP_IR_SHF  = 4'd11,
    TAP_IR_EX1  = 4'd12,
    TAP_IR_PAU  = 4'd13,
    TAP_IR_EX2  = 4'd14,
    TAP_IR_UPD  = 4'd15
  } tap_state_e;

  typedef struct packed {
    logic red;
    logic grn;
  } led_t;

endpackage

// File: rtl/tsl_rst_sync.sv
module tsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/tsl_tap_tracker.sv
module tsl_tap_tracker
  import tsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  input  logic       trst_n,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d, walk;

  always_comb begin
    case (state_q)
      TAP_RESET:  walk = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   walk = tms ? TAP_DR_SEL : TAP_IDLE;
      TAP_DR_SEL: walk = tms ? TAP_IR_SEL : TAP_DR_CAP;
      TAP_DR_CAP: walk = tms ? TAP_DR_EX1 : TAP_DR_SHF;
      TAP_DR_SHF: walk = tms ? TAP_DR_EX1 : TAP_DR_SHF;
      TAP_DR_EX1: walk = tms ? TAP_DR_UPD : TAP_DR_PAU;
      TAP_DR_PAU: walk = tms ? TAP_DR_EX2 : TAP_DR_PAU;
      TAP_DR_EX2: walk = tms ? TAP_DR_UPD : TAP_DR_SHF;
      TAP_DR_UPD: walk = tms ? TAP_DR_SEL : TAP_IDLE;
      TAP_IR_SEL: walk = tms ? TAP_RESET  : TAP_IR_CAP;
      TAP_IR_CAP: walk = tms ? TAP_IR_EX1 : TAP_IR_SHF;
      TAP_IR_SHF: walk = tms ? TAP_IR_EX1 : TAP_IR_SHF;
      TAP_IR_EX1: walk = tms ? TAP_IR_UPD : TAP_IR_PAU;
      TAP_IR_PAU: walk = tms ? TAP_IR_EX2 : TAP_IR_PAU;
      TAP_IR_EX2: walk = tms ? TAP_IR_UPD : TAP_IR_SHF;
      TAP_IR_UPD: walk = tms ? TAP_DR_SEL : TAP_IDLE;
      default:    walk = TAP_RESET;
    endcase
    state_d = trst_n ? walk : TAP_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TAP_RESET;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: test reset sampled low lands in Test-Logic-Reset
  assert_trst_forces_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |=> state_q == TAP_RESET);

  // R3: five ones on TMS always reach Test-Logic-Reset
  assert_five_ones_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)
    |=> state_q == TAP_RESET);

  // R1: Shift-IR can only stay, exit, or be reset
  assert_irshift_successor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == TAP_IR_SHF |=>
      (state_q == TAP_IR_SHF || state_q == TAP_IR_EX1 || state_q == TAP_RESET));

endmodule

// File: rtl/tsl_act_stretch.sv
module tsl_act_stretch #(
  parameter int STRETCH_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_act,
  input  logic blink_tick,
  output logic grn_o
);

  localparam int CNT_W = $clog2(STRETCH_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = host_act || (blink_tick && (cnt_q != '0));
    cnt_d  = host_act ? LOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign grn_o = (cnt_q != '0);

  // R7: a host pulse lights green on the next cycle
  assert_pulse_lights_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_act |=> grn_o);

  // R7: the count never runs past its load value
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

endmodule

// File: rtl/tsl_pwr_blink.sv
module tsl_pwr_blink (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_tick,
  input  logic from_host,
  input  logic retclk_seen,
  input  logic no_retclk_mode,
  output logic red_o,
  output logic grn_o
);

  logic phase_q, phase_d, need_blink;

  always_comb begin
    phase_d    = ~phase_q;
    need_blink = !from_host && !retclk_seen && !no_retclk_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= 1'b0;
    else if (blink_tick) phase_q <= phase_d;
  end

  assign grn_o = from_host;
  assign red_o = !from_host && (need_blink ? phase_q : 1'b1);

  // R9: while blinking, each tick flips the red output
  assert_blink_toggles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (need_blink && blink_tick) ##1 need_blink |-> red_o != $past(red_o));

endmodule

// File: rtl/tap_status_led.sv
module tap_status_led
  import tsl_pkg::*;
#(
  parameter int STRETCH_TICKS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tms,
  input  logic trst_n,
  input  logic host_act,
  input  logic pwr_from_host,
  input  logic retclk_seen,
  input  logic no_retclk_mode,
  input  logic blink_tick,
  output logic pwr_red,
  output logic pwr_grn,
  output logic act_red,
  output logic act_grn,
  output logic tap_red,
  output logic tap_grn
);

  logic       srst_n;
  tap_state_e tap_state;
  led_t       tap_led;

  tsl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(tck), .arst_n(rst_n), .srst_n(srst_n)
  );

  tsl_tap_tracker u_trk (
    .clk(tck), .rst_n(srst_n), .tms(tms), .trst_n(trst_n), .state_o(tap_state)
  );

  tsl_act_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_act (
    .clk(tck), .rst_n(srst_n), .host_act(host_act), .blink_tick(blink_tick),
    .grn_o(act_grn)
  );

  tsl_pwr_blink u_pwr (
    .clk(tck), .rst_n(srst_n), .blink_tick(blink_tick),
    .from_host(pwr_from_host), .retclk_seen(retclk_seen),
    .no_retclk_mode(no_retclk_mode), .red_o(pwr_red), .grn_o(pwr_grn)
  );

  always_comb begin
    case (tap_state)
      TAP_IDLE:               tap_led = '{red: 1'b0, grn: 1'b1};
      TAP_IR_SHF, TAP_IR_PAU: tap_led = '{red: 1'b1, grn: 1'b0};
      TAP_DR_SHF, TAP_DR_PAU: tap_led = '{red: 1'b1, grn: 1'b1};
      default:                tap_led = '{red: 1'b0, grn: 1'b0};
    endcase
  end

  assign tap_red = tap_led.red;
  assign tap_grn = tap_led.grn;
  assign act_red = !trst_n;

endmodule

// File: tb/tap_status_led_tb_top.sv
`timescale 1ns/1ps
module tap_status_led_tb_top;

  localparam int N = 4;

  logic tck = 1'b0;
  logic rst_n, tms, trst_n, host_act, pwr_from_host, retclk_seen, no_retclk_mode, blink_tick;
  logic pwr_red, pwr_grn, act_red, act_grn, tap_red, tap_grn;

  int n_chk = 0;
  int n_bad = 0;
  int m_state = 0;
  int m_cnt = 0;
  bit m_phase = 0;
  bit done = 0;

  always #4 tck = ~tck;

  tap_status_led #(.STRETCH_TICKS(N)) dut_i (
    .tck(tck), .rst_n(rst_n), .tms(tms), .trst_n(trst_n), .host_act(host_act),
    .pwr_from_host(pwr_from_host), .retclk_seen(retclk_seen),
    .no_retclk_mode(no_retclk_mode), .blink_tick(blink_tick),
    .pwr_red(pwr_red), .pwr_grn(pwr_grn), .act_red(act_red), .act_grn(act_grn),
    .tap_red(tap_red), .tap_grn(tap_grn)
  );

  // state codes of the bench: 0 reset, 1 idle, 2..8 DR column, 9..15 IR column
  function automatic int tap_next(int s, bit m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      3: return m ? 5 : 4;
      4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      8: return m ? 2 : 1;
      9: return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  function automatic bit exp_tred(int s);
    return (s == 11 || s == 13 || s == 4 || s == 6);
  endfunction

  function automatic bit exp_tgrn(int s);
    return (s == 1 || s == 4 || s == 6);
  endfunction

  function automatic bit exp_pred(bit fh, bit rc, bit nm, bit ph);
    if (fh) return 1'b0;
    if (!rc && !nm) return ph;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string stag);
    string st;
    st = (m_state <= 1) ? "R4" : "R5";
    chk({stag, "/", st, " tap_red"}, tap_red, exp_tred(m_state));
    chk({stag, "/", st, " tap_grn"}, tap_grn, exp_tgrn(m_state));
    chk("R6 act_red", act_red, !trst_n);
    chk("R7 act_grn", act_grn, m_cnt != 0);
    chk("R8 pwr_grn", pwr_grn, pwr_from_host);
    chk("R9 pwr_red", pwr_red, exp_pred(pwr_from_host, retclk_seen, no_retclk_mode, m_phase));
  endtask

  // drive at negedge, model at posedge, check after the edge
  task automatic step(bit t, bit tr, bit ha, bit tk, string stag);
    @(negedge tck);
    tms = t; trst_n = tr; host_act = ha; blink_tick = tk;
    @(posedge tck);
    m_state = tr ? tap_next(m_state, t) : 0;
    if (ha) m_cnt = N;
    else if (tk && m_cnt > 0) m_cnt--;
    if (tk) m_phase = ~m_phase;
    #2;
    check_all(stag);
  endtask

  task automatic do_reset();
    @(negedge tck);
    rst_n = 0; tms = 1; trst_n = 1; host_act = 0; blink_tick = 0;
    #1;
    m_state = 0; m_cnt = 0; m_phase = 0;
    check_all("R10");
    repeat (2) @(negedge tck);
    rst_n = 1;
    repeat (3) @(posedge tck);
    #2;
    check_all("R10");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pwr_from_host = 1; retclk_seen = 1; no_retclk_mode = 0;
    rst_n = 0; tms = 1; trst_n = 1; host_act = 0; blink_tick = 0;
    do_reset();

    // R1/R5: walk to Shift-DR then Pause-DR
    step(0, 1, 0, 0, "R1"); step(1, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R5");
    // R3: five ones from Pause-DR
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R3");
    // R1/R5: walk to Shift-IR then Pause-IR
    step(0, 1, 0, 0, "R4"); step(1, 1, 0, 0, "R1"); step(1, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R5");
    // R2: test reset from Pause-IR, act_red held (R6)
    step(0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R4");

    // R7: stretch exactly N ticks, reload wins over tick
    step(0, 1, 1, 0, "R7");
    for (int i = 0; i < N; i++) begin
      step(0, 1, 0, 0, "R7");
      step(0, 1, 0, 1, "R7");
    end
    step(0, 1, 1, 1, "R7");
    step(0, 1, 0, 1, "R7");

    // R8/R9: target power with and without return clock
    pwr_from_host = 0;
    step(0, 1, 0, 1, "R8");
    retclk_seen = 0;
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, "R9");
    no_retclk_mode = 1;
    step(0, 1, 0, 1, "R8");
    step(0, 1, 0, 0, "R8");

    // R10: asynchronous reset from Shift-DR mid-blink
    no_retclk_mode = 0;
    step(1, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R1"); step(0, 1, 0, 0, "R5");
    do_reset();

    // random run
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) pwr_from_host = ~pwr_from_host;
      if ($urandom_range(0, 29) == 0) retclk_seen = ~retclk_seen;
      if ($urandom_range(0, 59) == 0) no_retclk_mode = ~no_retclk_mode;
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 39) != 0),
           ($urandom_range(0, 11) == 0), ($urandom_range(0, 3) == 0), "R1");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule